// File: doc/BRIEF.md
# Settle-Discard Averaging Sequencer

This block decides, buffer by buffer, what happens to each completed block of correlated samples while a swept measurement is running. After the synthesizer is retuned, the first buffers still carry settling transients and must be thrown away. The buffers after them are summed into one measurement, and the downstream ratio unit is told when the sum is complete. A single down-counter handles both phases. It is loaded when a measurement starts, and it is compared against a threshold taken from the bandwidth code. At or above the threshold a buffer is discarded and the accumulators are cleared. Below it, the buffer is accumulated.

The controller raises a one-cycle start pulse carrying a settling delay, counted in buffers, and a bandwidth code. The sample interface raises a one-cycle strobe each time a buffer finishes, together with a flag that tells which half of the double-buffered capture memory has just filled. The sequencer answers each strobe one cycle later. It either issues a clear command for the accumulators, or issues a process command that names the half to read. With the last processed buffer it pulses done and drops busy.

Top module: `sad_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, acc_clear_o, proc_o, proc_half_o, done_o and busy_o are all 0.
- R2: A start_i pulse makes acc_clear_o and busy_o 1 in the following cycle.
- R3: Of the buffers completed while busy, the first settle+1 are discarded: each one gives a one-cycle acc_clear_o in the cycle after its strobe, and proc_o stays 0.
- R4: The next bw+1 buffers are averaged: each one gives a one-cycle proc_o in the cycle after its strobe, and proc_half_o then equals the buf_half_i value sampled with that strobe (0 = lower half, 1 = upper half).
- R5: done_o is 1 for exactly one cycle, in the same cycle as the proc_o of the last averaged buffer. busy_o is 0 from that cycle on.
- R6: Buffer strobes that arrive while not busy produce no acc_clear_o, no proc_o and no done_o.
- R7: A start_i pulse while busy discards the measurement in progress. It reloads the sequence from the new settle and bandwidth inputs and clears the accumulators again.
- R8: A buffer strobe in the same cycle as start_i is ignored. Only the start takes effect.
- R9: The bandwidth code is the number of buffers to average minus one. The codes 0, 3, 39 and 131 give 1, 4, 40 and 132 averaged buffers.
- R10: settle_i and bw_code_i are sampled only on start_i. Changing them during a measurement has no effect on that measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Measurement start pulse |
| settle_i | input | SETTLE_W | Extra settling buffers to discard |
| bw_code_i | input | BW_W | Buffers to average minus one |
| buf_done_i | input | 1 | One-cycle buffer-complete strobe |
| buf_half_i | input | 1 | Half of capture memory just filled |
| acc_clear_o | output | 1 | Clear accumulators command |
| proc_o | output | 1 | Accumulate this buffer command |
| proc_half_o | output | 1 | Half to accumulate, valid with proc_o |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | Averaging finished, ratio may be computed |

## Verification
The assertions assume that start_i and buf_done_i are single-cycle pulses, and that buf_half_i is stable in the cycle its strobe is high. The bench only ever holds each pulse for one clock and changes inputs on the falling edge, so every sample the design takes is clean. Coincident start and strobe, and input changes in the middle of a measurement, are produced on purpose, because the design must tolerate both.

// File: rtl/sad_pkg.sv
package sad_pkg;

  typedef enum logic [1:0] {
    VERDICT_NONE    = 2'd0,
    VERDICT_DISCARD = 2'd1,
    VERDICT_AVERAGE = 2'd2
  } verdict_e;

  // Counter preload: settle+1 discards followed by bw+1 averages.
  function automatic int load_count(input int settle, input int bw);
    return settle + bw + 2;
  endfunction

  // Count value at or above which a buffer is thrown away.
  function automatic int discard_floor(input int bw);
    return bw + 2;
  endfunction

endpackage

// File: rtl/sad_wait_counter.sv
module sad_wait_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (load_i) begin
      count_q <= load_val_i;
    end else if (dec_i) begin
      count_q <= count_q - CNT_W'(1);
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/sad_buf_classify.sv
module sad_buf_classify #(
  parameter int CNT_W = 10,
  parameter int BW_W  = 8
) (
  input  logic              evt_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [BW_W-1:0]   bw_i,
  output sad_pkg::verdict_e verdict_o,
  output logic              last_o
);

  logic above;

  always_comb begin
    above = int'(count_i) >= sad_pkg::discard_floor(int'(bw_i));
    if (!evt_i) begin
      verdict_o = sad_pkg::VERDICT_NONE;
    end else if (above) begin
      verdict_o = sad_pkg::VERDICT_DISCARD;
    end else begin
      verdict_o = sad_pkg::VERDICT_AVERAGE;
    end
    last_o = (verdict_o == sad_pkg::VERDICT_AVERAGE) && (count_i == CNT_W'(1));
  end

endmodule

// File: rtl/sad_sequencer.sv
module sad_sequencer #(
  parameter int SETTLE_W = 8,
  parameter int BW_W     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [BW_W-1:0]     bw_code_i,
  input  logic                buf_done_i,
  input  logic                buf_half_i,
  output logic                acc_clear_o,
  output logic                proc_o,
  output logic                proc_half_o,
  output logic                busy_o,
  output logic                done_o
);

  localparam int WIDEST = (SETTLE_W > BW_W) ? SETTLE_W : BW_W;
  localparam int CNT_W  = WIDEST + 2;

  logic              busy_q;
  logic [BW_W-1:0]   bw_q;
  logic [CNT_W-1:0]  wait_cnt;
  logic [CNT_W-1:0]  load_val;
  sad_pkg::verdict_e verdict;

  // Named internal events, visible to the checker.
  logic buf_evt;
  logic discard_evt;
  logic avg_evt;
  logic last_evt;

  logic acc_clear_q, proc_q, half_q, done_q;

  assign buf_evt     = buf_done_i && busy_q && !start_i;
  assign load_val    = CNT_W'(sad_pkg::load_count(int'(settle_i), int'(bw_code_i)));
  assign discard_evt = (verdict == sad_pkg::VERDICT_DISCARD);
  assign avg_evt     = (verdict == sad_pkg::VERDICT_AVERAGE);

  sad_wait_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start_i),
    .load_val_i (load_val),
    .dec_i      (buf_evt),
    .count_o    (wait_cnt)
  );

  sad_buf_classify #(.CNT_W(CNT_W), .BW_W(BW_W)) u_cls (
    .evt_i     (buf_evt),
    .count_i   (wait_cnt),
    .bw_i      (bw_q),
    .verdict_o (verdict),
    .last_o    (last_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bw_q   <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      bw_q   <= bw_code_i;
    end else if (last_evt) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_clear_q <= 1'b0;
      proc_q      <= 1'b0;
      half_q      <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      acc_clear_q <= start_i || discard_evt;
      proc_q      <= avg_evt;
      done_q      <= last_evt;
      if (avg_evt) begin
        half_q <= buf_half_i;
      end
    end
  end

  assign acc_clear_o = acc_clear_q;
  assign proc_o      = proc_q;
  assign proc_half_o = half_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;

endmodule

// File: rtl/sad_sequencer_chk.sv
module sad_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic buf_done_i,
  input logic buf_half_i,
  input logic acc_clear_o,
  input logic proc_o,
  input logic proc_half_o,
  input logic busy_o,
  input logic done_o,
  input logic discard_evt,
  input logic avg_evt,
  input logic last_evt
);

  p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> acc_clear_o && busy_o);

  p_clear_not_proc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_clear_o && proc_o));

  p_discard_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    discard_evt |=> acc_clear_o && !proc_o);

  p_avg_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    avg_evt |=> proc_o && (proc_half_o == $past(buf_half_i)));

  p_done_with_proc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> proc_o && !busy_o);

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_last_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt && !start_i |=> done_o && !busy_o);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i |=> !proc_o && !acc_clear_o);

  p_coincident_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && buf_done_i |=> !proc_o && !done_o && busy_o);

endmodule

bind sad_sequencer sad_sequencer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .buf_done_i  (buf_done_i),
  .buf_half_i  (buf_half_i),
  .acc_clear_o (acc_clear_o),
  .proc_o      (proc_o),
  .proc_half_o (proc_half_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .discard_evt (discard_evt),
  .avg_evt     (avg_evt),
  .last_evt    (last_evt)
);

// File: tb/test_sad_sequencer.sv
`timescale 1ns/1ps
module test_sad_sequencer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] settle_i = '0;
  logic [7:0] bw_code_i = '0;
  logic       buf_done_i = 1'b0;
  logic       buf_half_i = 1'b0;
  logic       acc_clear_o, proc_o, proc_half_o, busy_o, done_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #10 clk = ~clk;

  sad_sequencer i_sad_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .settle_i(settle_i),
    .bw_code_i(bw_code_i), .buf_done_i(buf_done_i), .buf_half_i(buf_half_i),
    .acc_clear_o(acc_clear_o), .proc_o(proc_o), .proc_half_o(proc_half_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  // Behavioural model: separate discard and average budgets.
  int m_disc_left = 0;
  int m_avg_left  = 0;
  bit m_active    = 0;
  bit e_clear = 0, e_proc = 0, e_half = 0, e_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_disc_left = 0; m_avg_left = 0;
      e_clear = 0; e_proc = 0; e_half = 0; e_done = 0;
    end else begin
      e_clear = 0; e_proc = 0; e_done = 0;
      if (start_i) begin
        m_active    = 1;
        m_disc_left = int'(settle_i) + 1;
        m_avg_left  = int'(bw_code_i) + 1;
        e_clear     = 1;
      end else if (buf_done_i && m_active) begin
        if (m_disc_left > 0) begin
          m_disc_left--;
          e_clear = 1;
        end else begin
          m_avg_left--;
          e_proc = 1;
          e_half = buf_half_i;
          if (m_avg_left == 0) begin
            e_done   = 1;
            m_active = 0;
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Monitor and per-clock comparison.
  int clr_cnt = 0, proc_cnt = 0, done_cnt = 0;

  always @(negedge clk) begin
    clr_cnt  += int'(acc_clear_o);
    proc_cnt += int'(proc_o);
    done_cnt += int'(done_o);
    if (done_o !== e_done)
      check(0, "R5 done", int'(done_o), int'(e_done));
    else if (proc_o !== e_proc)
      check(0, "R4 proc", int'(proc_o), int'(e_proc));
    else if (proc_o && (proc_half_o !== e_half))
      check(0, "R4 half", int'(proc_half_o), int'(e_half));
    else if (acc_clear_o !== e_clear)
      check(0, "R3 clear", int'(acc_clear_o), int'(e_clear));
    else if (busy_o !== m_active)
      check(0, "R2 busy", int'(busy_o), int'(m_active));
    else
      check(1, "R2", 0, 0);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic zero_counts();
    clr_cnt = 0; proc_cnt = 0; done_cnt = 0;
  endtask

  task automatic start(input int s, input int b);
    @(negedge clk);
    zero_counts();
    settle_i = 8'(s); bw_code_i = 8'(b); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  bit half_tgl = 0;
  task automatic send_buf();
    buf_half_i = half_tgl;
    half_tgl   = ~half_tgl;
    buf_done_i = 1'b1;
    @(negedge clk);
    buf_done_i = 1'b0;
    idle(1);
  endtask

  task automatic run_meas(input int s, input int b);
    start(s, b);
    for (int i = 0; i < s + b + 2; i++) send_buf();
    idle(2);
    check(proc_cnt == b + 1, "R9 averaged count", proc_cnt, b + 1);
    check(clr_cnt == s + 2, "R3 clear count", clr_cnt, s + 2);
    check(done_cnt == 1, "R5 done count", done_cnt, 1);
    check(busy_o == 1'b0, "R5 busy after done", int'(busy_o), 0);
  endtask

  initial begin
    idle(3);
    check({acc_clear_o, proc_o, proc_half_o, busy_o, done_o} == 5'b0, "R1 reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({acc_clear_o, proc_o, proc_half_o, busy_o, done_o} == 5'b0, "R1 after reset", 0, 0);

    // R6: strobes while idle
    zero_counts();
    for (int i = 0; i < 3; i++) send_buf();
    check(proc_cnt == 0 && clr_cnt == 0 && done_cnt == 0, "R6 idle strobes", proc_cnt + clr_cnt, 0);

    // R2/R9: the four bandwidth codes
    run_meas(2, 3);
    run_meas(0, 0);
    run_meas(5, 39);
    run_meas(1, 131);

    // R7: restart while busy
    start(1, 3);
    for (int i = 0; i < 4; i++) send_buf();
    check(busy_o == 1'b1, "R7 busy before restart", int'(busy_o), 1);
    start(0, 2);
    check(acc_clear_o == 1'b1, "R7 restart clears", int'(acc_clear_o), 1);
    for (int i = 0; i < 4; i++) send_buf();
    idle(2);
    check(proc_cnt == 3, "R7 averaged after restart", proc_cnt, 3);
    check(done_cnt == 1, "R7 done after restart", done_cnt, 1);

    // R8: strobe coincident with start
    @(negedge clk);
    zero_counts();
    settle_i = 8'd0; bw_code_i = 8'd1; start_i = 1'b1; buf_done_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; buf_done_i = 1'b0;
    check(proc_o == 1'b0 && acc_clear_o == 1'b1, "R8 start wins", int'(proc_o), 0);
    for (int i = 0; i < 3; i++) send_buf();
    idle(2);
    check(proc_cnt == 2 && clr_cnt == 2, "R8 sequence intact", proc_cnt, 2);

    // R10: inputs changed mid-measurement
    start(1, 4);
    settle_i = 8'd9; bw_code_i = 8'd0;
    for (int i = 0; i < 7; i++) send_buf();
    idle(2);
    check(proc_cnt == 5, "R10 latched bandwidth", proc_cnt, 5);
    check(clr_cnt == 3, "R10 latched settle", clr_cnt, 3);
    check(done_cnt == 1, "R10 done", done_cnt, 1);

    idle(3);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      check(0, "watchdog", cycles, 100000);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule